// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block takes one trap request per cycle (cause, faulting instruction address, an optional faulting data address) and turns it into a new fetch address, a new privilege level and the saved context that goes with it. Each trap lands in one of four places. A software breakpoint may enter debug mode. A trap taken while debug mode is active is redirected to the debug exception handler. Otherwise the trap goes to supervisor mode when the delegation masks allow it, or to machine mode.

The unit holds the context it writes: the fetch address it last redirected to, the current privilege, the supervisor and machine exception PC, cause and bad-address registers, the interrupt-enable stack bits, the debug cause, the debug privilege, the debug PC and the load-reservation flag. Vector bases, delegation masks and per-level breakpoint enables come in as inputs from the surrounding control-register file. A context-load port lets the core set the privilege and the live interrupt enables, for example on a trap return. A reservation-set input marks an open load reservation.

Privilege encoding is 0 user, 1 supervisor, 2 hypervisor, 3 machine. Cause code 3 is the breakpoint exception. The most significant cause bit marks an interrupt.

Top module: `trap_router`

## Requirements
- R1: Out of reset the privilege is 3, the fetch address is RESET_PC, all saved-context registers and status bits are 0, the debug cause is 0 and no reservation is held.
- R2: A trap with cause exactly 3, taken when brk_en bit [current privilege] is 1, enters debug mode. On the next cycle the fetch address is DBG_ROM, the privilege is 3, the debug cause is 1, the debug privilege holds the old privilege and the debug PC holds trap_epc. This check takes priority even when debug mode is already active.
- R3: A breakpoint trap whose level's brk_en bit is 0 is handled as an ordinary exception.
- R4: While the debug cause is nonzero, any trap that R2 does not claim sets the fetch address to DBG_EXC and changes no other state. The debug cause changes only on a trap.
- R5: An interrupt (cause bit XLEN-1 set) looks up ideleg. An exception looks up edeleg. The index is the cause with bit XLEN-1 cleared. The trap goes to supervisor mode only if the privilege is 0 or 1, the index is below XLEN and the indexed mask bit is 1.
- R6: Supervisor entry sets the fetch address to stvec, scause to the full cause and sepc to trap_epc. It writes sbad with trap_addr only when trap_has_addr is 1. The machine registers are left alone.
- R7: Supervisor entry copies the old level's live enable bit (uie for 0, sie for 1) into spie. It writes bit 0 of the old privilege into spp, clears sie and sets the privilege to 1.
- R8: Machine entry sets the fetch address to mtvec, mcause to the cause, mepc to trap_epc, and mbad to trap_addr only when trap_has_addr is 1. It copies the old level's enable bit (uie, sie, 0 for level 2, mie) into mpie and the old privilege into mpp, clears mie and sets the privilege to 3.
- R9: Supervisor and machine entries clear the load reservation. Both debug paths leave it unchanged.
- R10: Without a trap, ctx_load loads the privilege from ctx_priv and the live enables from ctx_ie (bit 0 uie, bit 1 sie, bit 2 mie), and resv_set sets the reservation. In the same cycle as a trap, both are ignored and the trap is taken against the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_valid | input | 1 | Trap request this cycle |
| trap_cause | input | XLEN | Cause; top bit marks an interrupt |
| trap_epc | input | XLEN | Address of the trapping instruction |
| trap_has_addr | input | 1 | trap_addr is meaningful |
| trap_addr | input | XLEN | Faulting address |
| stvec | input | XLEN | Supervisor vector base |
| mtvec | input | XLEN | Machine vector base |
| edeleg | input | XLEN | Exception delegation mask |
| ideleg | input | XLEN | Interrupt delegation mask |
| brk_en | input | 4 | Breakpoint-to-debug enable per privilege |
| ctx_load | input | 1 | Load privilege and live enables |
| ctx_priv | input | 2 | Privilege to load |
| ctx_ie | input | 3 | {mie, sie, uie} to load |
| resv_set | input | 1 | Open a load reservation |
| pc_out | output | XLEN | Current redirect fetch address |
| priv_out | output | 2 | Current privilege |
| sepc | output | XLEN | Supervisor exception PC |
| scause | output | XLEN | Supervisor cause |
| sbad | output | XLEN | Supervisor bad address |
| mepc | output | XLEN | Machine exception PC |
| mcause | output | XLEN | Machine cause |
| mbad | output | XLEN | Machine bad address |
| st_uie | output | 1 | User interrupt enable |
| st_sie | output | 1 | Supervisor interrupt enable |
| st_mie | output | 1 | Machine interrupt enable |
| st_spie | output | 1 | Supervisor previous enable |
| st_mpie | output | 1 | Machine previous enable |
| st_spp | output | 1 | Supervisor previous privilege |
| st_mpp | output | 2 | Machine previous privilege |
| dbg_cause | output | 3 | Debug entry cause, 0 when not in debug |
| dbg_prv | output | 2 | Privilege at debug entry |
| dpc | output | XLEN | Debug PC |
| resv_valid | output | 1 | Load reservation held |

## Verification
Every result of a trap, context load or reservation set appears on the outputs one clock edge after the request. No output depends combinationally on the inputs. The bench changes inputs on the falling edge and holds a request for exactly one cycle. It reads the outputs at the following falling edge, half a cycle after the edge that registered them, so each check sees the settled value of that single update and nothing later.

// File: rtl/trap_pkg.sv
// Shared constants and types for the trap entry unit.
// Assumes the privilege encoding U=0, S=1, H=2, M=3.
package trap_pkg;
    localparam logic [1:0] PRV_U = 2'd0;
    localparam logic [1:0] PRV_S = 2'd1;
    localparam logic [1:0] PRV_H = 2'd2;
    localparam logic [1:0] PRV_M = 2'd3;

    localparam logic [2:0] DBG_SWBP  = 3'd1;
    localparam int unsigned BRK_CODE = 3;

    typedef enum logic [1:0] {
        RT_MACH      = 2'd0,
        RT_SUPV      = 2'd1,
        RT_DBG_ENTER = 2'd2,
        RT_DBG_REDIR = 2'd3
    } route_e;

    typedef struct packed {
        logic       uie;
        logic       sie;
        logic       mie;
        logic       spie;
        logic       mpie;
        logic       spp;
        logic [1:0] mpp;
    } stat_t;
endpackage

// File: rtl/trap_route_decide.sv
// Picks the destination of a trap: debug entry, debug redirect,
// supervisor or machine. Purely combinational.
// Assumes XLEN is a power of two and at least 8.
module trap_route_decide
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cause,
    input  logic [1:0]      priv,
    input  logic [XLEN-1:0] edeleg,
    input  logic [XLEN-1:0] ideleg,
    input  logic [3:0]      brk_en,
    input  logic            in_debug,
    output route_e          route
);
    localparam int IW = $clog2(XLEN);
    localparam logic [XLEN-1:0] XLEN_V = XLEN[XLEN-1:0];
    localparam logic [XLEN-1:0] BRK_V  = BRK_CODE[XLEN-1:0];

    logic            is_irq;
    logic [XLEN-1:0] idx;
    logic [XLEN-1:0] mask;
    logic            in_range;
    logic            deleg_hit;
    logic            brk_hit;

    // Form the delegation index and look up the matching mask bit.
    always_comb begin
        is_irq    = cause[XLEN-1];
        idx       = {1'b0, cause[XLEN-2:0]};
        mask      = is_irq ? ideleg : edeleg;
        in_range  = (idx < XLEN_V);
        deleg_hit = in_range && mask[idx[IW-1:0]];
        brk_hit   = (cause == BRK_V) && brk_en[priv];
    end

    // Apply the fixed priority: breakpoint, in-debug, delegation, machine.
    always_comb begin
        if (brk_hit)
            route = RT_DBG_ENTER;
        else if (in_debug)
            route = RT_DBG_REDIR;
        else if ((priv <= PRV_S) && deleg_hit)
            route = RT_SUPV;
        else
            route = RT_MACH;
    end
endmodule

// File: rtl/trap_status_stack.sv
// Computes the interrupt-enable stack after a trap for a given route.
// Leaves the status unchanged for the two debug routes.
// Assumes level 2 has no live enable bit of its own.
module trap_status_stack
    import trap_pkg::*;
(
    input  route_e     route,
    input  logic [1:0] priv,
    input  stat_t      cur,
    output stat_t      nxt
);
    logic cur_ie;

    // Select the live enable bit belonging to the current level.
    always_comb begin
        case (priv)
            PRV_U:   cur_ie = cur.uie;
            PRV_S:   cur_ie = cur.sie;
            PRV_M:   cur_ie = cur.mie;
            default: cur_ie = 1'b0;
        endcase
    end

    // Push the enable and privilege onto the target level's stack.
    always_comb begin
        nxt = cur;
        case (route)
            RT_SUPV: begin
                nxt.spie = cur_ie;
                nxt.spp  = priv[0];
                nxt.sie  = 1'b0;
            end
            RT_MACH: begin
                nxt.mpie = cur_ie;
                nxt.mpp  = priv;
                nxt.mie  = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/trap_debug_state.sv
// Holds the debug cause, debug privilege and debug PC.
// Written only on a breakpoint debug entry; cleared by reset.
module trap_debug_state
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter,
    input  logic [XLEN-1:0] epc,
    input  logic [1:0]      priv,
    output logic [2:0]      cause_q,
    output logic [1:0]      prv_q,
    output logic [XLEN-1:0] dpc_q,
    output logic            active
);
    // Capture the entry context on a breakpoint debug entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            prv_q   <= '0;
            dpc_q   <= '0;
        end else if (enter) begin
            cause_q <= DBG_SWBP;
            prv_q   <= priv;
            dpc_q   <= epc;
        end
    end

    assign active = (cause_q != 3'd0);
endmodule

// File: rtl/trap_router.sv
// Trap entry unit: applies one trap per cycle and keeps the saved
// context. All results are registered and show one cycle later.
// Assumes vectors, masks and breakpoint enables are stable inputs.
module trap_router
    import trap_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = 'h80,
    parameter logic [XLEN-1:0] DBG_ROM  = 'h800,
    parameter logic [XLEN-1:0] DBG_EXC  = 'h808
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_valid,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_epc,
    input  logic            trap_has_addr,
    input  logic [XLEN-1:0] trap_addr,
    input  logic [XLEN-1:0] stvec,
    input  logic [XLEN-1:0] mtvec,
    input  logic [XLEN-1:0] edeleg,
    input  logic [XLEN-1:0] ideleg,
    input  logic [3:0]      brk_en,
    input  logic            ctx_load,
    input  logic [1:0]      ctx_priv,
    input  logic [2:0]      ctx_ie,
    input  logic            resv_set,
    output logic [XLEN-1:0] pc_out,
    output logic [1:0]      priv_out,
    output logic [XLEN-1:0] sepc,
    output logic [XLEN-1:0] scause,
    output logic [XLEN-1:0] sbad,
    output logic [XLEN-1:0] mepc,
    output logic [XLEN-1:0] mcause,
    output logic [XLEN-1:0] mbad,
    output logic            st_uie,
    output logic            st_sie,
    output logic            st_mie,
    output logic            st_spie,
    output logic            st_mpie,
    output logic            st_spp,
    output logic [1:0]      st_mpp,
    output logic [2:0]      dbg_cause,
    output logic [1:0]      dbg_prv,
    output logic [XLEN-1:0] dpc,
    output logic            resv_valid
);
    route_e route;
    stat_t  stat_q;
    stat_t  stat_nxt;
    logic   in_debug;
    logic   dbg_enter;
    logic   take_s;
    logic   take_m;

    trap_route_decide #(.XLEN(XLEN)) u_decide (
        .cause    (trap_cause),
        .priv     (priv_out),
        .edeleg   (edeleg),
        .ideleg   (ideleg),
        .brk_en   (brk_en),
        .in_debug (in_debug),
        .route    (route)
    );

    trap_status_stack u_stack (
        .route (route),
        .priv  (priv_out),
        .cur   (stat_q),
        .nxt   (stat_nxt)
    );

    assign dbg_enter = trap_valid && (route == RT_DBG_ENTER);
    assign take_s    = trap_valid && (route == RT_SUPV);
    assign take_m    = trap_valid && (route == RT_MACH);

    trap_debug_state #(.XLEN(XLEN)) u_debug (
        .clk     (clk),
        .rst_n   (rst_n),
        .enter   (dbg_enter),
        .epc     (trap_epc),
        .priv    (priv_out),
        .cause_q (dbg_cause),
        .prv_q   (dbg_prv),
        .dpc_q   (dpc),
        .active  (in_debug)
    );

    // Redirect the fetch address and set the new privilege.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_out   <= RESET_PC;
            priv_out <= PRV_M;
        end else if (trap_valid) begin
            case (route)
                RT_DBG_ENTER: begin
                    pc_out   <= DBG_ROM;
                    priv_out <= PRV_M;
                end
                RT_DBG_REDIR: pc_out <= DBG_EXC;
                RT_SUPV: begin
                    pc_out   <= stvec;
                    priv_out <= PRV_S;
                end
                default: begin
                    pc_out   <= mtvec;
                    priv_out <= PRV_M;
                end
            endcase
        end else if (ctx_load) begin
            priv_out <= ctx_priv;
        end
    end

    // Record cause, exception PC and bad address for supervisor entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sepc   <= '0;
            scause <= '0;
            sbad   <= '0;
        end else if (take_s) begin
            sepc   <= trap_epc;
            scause <= trap_cause;
            if (trap_has_addr)
                sbad <= trap_addr;
        end
    end

    // Record cause, exception PC and bad address for machine entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mepc   <= '0;
            mcause <= '0;
            mbad   <= '0;
        end else if (take_m) begin
            mepc   <= trap_epc;
            mcause <= trap_cause;
            if (trap_has_addr)
                mbad <= trap_addr;
        end
    end

    // Update the enable stack on a trap, or the live enables on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (trap_valid) begin
            stat_q <= stat_nxt;
        end else if (ctx_load) begin
            stat_q.uie <= ctx_ie[0];
            stat_q.sie <= ctx_ie[1];
            stat_q.mie <= ctx_ie[2];
        end
    end

    // Track the load reservation; ordinary trap entries drop it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            resv_valid <= 1'b0;
        else if (take_s || take_m)
            resv_valid <= 1'b0;
        else if (!trap_valid && resv_set)
            resv_valid <= 1'b1;
    end

    assign st_uie  = stat_q.uie;
    assign st_sie  = stat_q.sie;
    assign st_mie  = stat_q.mie;
    assign st_spie = stat_q.spie;
    assign st_mpie = stat_q.mpie;
    assign st_spp  = stat_q.spp;
    assign st_mpp  = stat_q.mpp;
endmodule

// File: rtl/trap_router_chk.sv
// Property checker for the trap entry unit, bound to every instance.
// Observes ports only; all properties are disabled during reset.
module trap_router_chk #(
    parameter int              XLEN    = 32,
    parameter logic [XLEN-1:0] DBG_ROM = 'h800,
    parameter logic [XLEN-1:0] DBG_EXC = 'h808
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_valid,
    input logic [XLEN-1:0] trap_cause,
    input logic [XLEN-1:0] trap_epc,
    input logic [XLEN-1:0] mtvec,
    input logic [3:0]      brk_en,
    input logic            ctx_load,
    input logic [1:0]      ctx_priv,
    input logic [XLEN-1:0] pc_out,
    input logic [1:0]      priv_out,
    input logic            st_mie,
    input logic [2:0]      dbg_cause,
    input logic [XLEN-1:0] dpc,
    input logic            resv_valid
);
    localparam logic [XLEN-1:0] BRK = 'd3;

    logic brk_now;
    assign brk_now = (trap_cause == BRK) && brk_en[priv_out];

    assert_brk_debug_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && brk_now) |=>
        (priv_out == 2'd3 && pc_out == DBG_ROM && dbg_cause == 3'd1 && dpc == $past(trap_epc)));

    assert_dbg_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && dbg_cause != 3'd0 && !brk_now) |=>
        (pc_out == DBG_EXC && priv_out == $past(priv_out) && dbg_cause == $past(dbg_cause)));

    assert_dbg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> $stable(dbg_cause));

    assert_mach_from_m_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && dbg_cause == 3'd0 && !brk_now && priv_out == 2'd3) |=>
        (priv_out == 2'd3 && pc_out == $past(mtvec) && !st_mie));

    assert_resv_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && dbg_cause == 3'd0 && !brk_now) |=> !resv_valid);

    assert_ctx_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_load && !trap_valid) |=> (priv_out == $past(ctx_priv)));
endmodule

bind trap_router trap_router_chk #(
    .XLEN    (XLEN),
    .DBG_ROM (DBG_ROM),
    .DBG_EXC (DBG_EXC)
) u_chk (.*);

// File: tb/trap_router_test.sv
`timescale 1ns/1ps
// Directed bench for the trap entry unit: one task per scenario.
module trap_router_test;
    localparam int XLEN = 32;
    localparam logic [31:0] RST_PC = 32'h80;
    localparam logic [31:0] ROM    = 32'h800;
    localparam logic [31:0] EXC    = 32'h808;
    localparam logic [31:0] STV    = 32'h2000;
    localparam logic [31:0] MTV    = 32'h1000;
    localparam logic [31:0] IRQ    = 32'h8000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_valid = 0, trap_has_addr = 0, ctx_load = 0, resv_set = 0;
    logic [31:0] trap_cause = 0, trap_epc = 0, trap_addr = 0;
    logic [31:0] stvec = STV, mtvec = MTV, edeleg = 0, ideleg = 0;
    logic [3:0]  brk_en = 0;
    logic [1:0]  ctx_priv = 0;
    logic [2:0]  ctx_ie = 0;
    logic [31:0] pc_out, sepc, scause, sbad, mepc, mcause, mbad, dpc;
    logic [1:0]  priv_out, st_mpp, dbg_prv;
    logic [2:0]  dbg_cause;
    logic st_uie, st_sie, st_mie, st_spie, st_mpie, st_spp, resv_valid;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    trap_router #(.XLEN(XLEN), .RESET_PC(RST_PC), .DBG_ROM(ROM), .DBG_EXC(EXC)) uut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        trap_valid = 0; ctx_load = 0; resv_set = 0;
        edeleg = 0; ideleg = 0; brk_en = 0; trap_has_addr = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic trap(input logic [31:0] c, input logic [31:0] epc,
                        input logic has, input logic [31:0] a);
        @(negedge clk);
        trap_valid = 1; trap_cause = c; trap_epc = epc;
        trap_has_addr = has; trap_addr = a;
        @(negedge clk);
        trap_valid = 0; trap_has_addr = 0;
    endtask

    task automatic load_ctx(input logic [1:0] p, input logic [2:0] ie);
        @(negedge clk);
        ctx_load = 1; ctx_priv = p; ctx_ie = ie;
        @(negedge clk);
        ctx_load = 0;
    endtask

    task automatic open_resv();
        @(negedge clk);
        resv_set = 1;
        @(negedge clk);
        resv_set = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 priv", priv_out, 3);
        check("R1 pc", pc_out, RST_PC);
        check("R1 status", {st_uie, st_sie, st_mie, st_spie, st_mpie, st_spp, st_mpp}, 0);
        check("R1 dbg_cause", dbg_cause, 0);
        check("R1 mcause", mcause, 0);
        check("R1 resv", resv_valid, 0);
    endtask

    task automatic t_debug_entry_redirect();
        do_reset();
        load_ctx(2'd0, 3'b000);
        open_resv();
        brk_en = 4'b0001;
        trap(32'd3, 32'h140, 0, 0);
        check("R2 pc", pc_out, ROM);
        check("R2 priv", priv_out, 3);
        check("R2 cause", dbg_cause, 1);
        check("R2 dbg_prv", dbg_prv, 0);
        check("R2 dpc", dpc, 32'h140);
        check("R9 debug keeps resv", resv_valid, 1);
        trap(32'd5, 32'h200, 1, 32'h77);
        check("R4 redirect pc", pc_out, EXC);
        check("R4 priv kept", priv_out, 3);
        check("R4 dpc kept", dpc, 32'h140);
        check("R4 mcause kept", mcause, 0);
        check("R4 mbad kept", mbad, 0);
        check("R4 resv kept", resv_valid, 1);
        brk_en = 4'b1000;
        trap(32'd3, 32'h300, 0, 0);
        check("R2 priority in debug pc", pc_out, ROM);
        check("R2 priority in debug dpc", dpc, 32'h300);
        check("R2 priority dbg_prv", dbg_prv, 3);
    endtask

    task automatic t_brk_disabled();
        do_reset();
        brk_en = 4'b0111;
        trap(32'd3, 32'h40, 0, 0);
        check("R3 pc", pc_out, MTV);
        check("R3 mcause", mcause, 3);
        check("R3 mepc", mepc, 32'h40);
        check("R3 no debug", dbg_cause, 0);
    endtask

    task automatic t_super_exception();
        do_reset();
        edeleg = 32'h100;
        load_ctx(2'd0, 3'b101);
        open_resv();
        trap(32'd8, 32'h300, 1, 32'hdead);
        check("R6 pc", pc_out, STV);
        check("R6 scause", scause, 8);
        check("R6 sepc", sepc, 32'h300);
        check("R6 sbad", sbad, 32'hdead);
        check("R6 mcause kept", mcause, 0);
        check("R7 priv", priv_out, 1);
        check("R7 spie from uie", st_spie, 1);
        check("R7 spp", st_spp, 0);
        check("R7 sie", st_sie, 0);
        check("R7 mie kept", st_mie, 1);
        check("R9 resv cleared", resv_valid, 0);
    endtask

    task automatic t_super_interrupt();
        do_reset();
        ideleg = 32'h20;
        load_ctx(2'd1, 3'b010);
        trap(IRQ | 32'd5, 32'h480, 0, 32'h55);
        check("R5 irq delegated pc", pc_out, STV);
        check("R6 scause irq", scause, IRQ | 32'd5);
        check("R6 sbad unwritten", sbad, 0);
        check("R7 spie from sie", st_spie, 1);
        check("R7 spp from S", st_spp, 1);
        check("R7 sie cleared", st_sie, 0);
        check("R7 priv S", priv_out, 1);
    endtask

    task automatic t_irq_uses_ideleg();
        do_reset();
        edeleg = 32'h20;
        load_ctx(2'd0, 3'b001);
        trap(IRQ | 32'd5, 32'h500, 1, 32'h99);
        check("R5 irq ignores edeleg", pc_out, MTV);
        check("R8 mcause", mcause, IRQ | 32'd5);
        check("R8 mbad", mbad, 32'h99);
        check("R8 mpie from uie", st_mpie, 1);
        check("R8 mpp", st_mpp, 0);
        check("R8 priv", priv_out, 3);
        check("R6 scause kept", scause, 0);
    endtask

    task automatic t_no_deleg_from_m();
        do_reset();
        edeleg = 32'hffff_ffff;
        load_ctx(2'd3, 3'b100);
        trap(32'd2, 32'h600, 0, 32'h11);
        check("R5 M not delegated", pc_out, MTV);
        check("R8 mpie from mie", st_mpie, 1);
        check("R8 mpp M", st_mpp, 3);
        check("R8 mie cleared", st_mie, 0);
        check("R8 mbad unwritten", mbad, 0);
    endtask

    task automatic t_index_range();
        do_reset();
        ideleg = 32'hffff_ffff;
        load_ctx(2'd0, 3'b000);
        trap(IRQ | 32'd40, 32'h700, 0, 0);
        check("R5 index above XLEN to M", pc_out, MTV);
        check("R5 index above XLEN priv", priv_out, 3);
        do_reset();
        ideleg = 32'h1;
        load_ctx(2'd2, 3'b111);
        trap(IRQ, 32'h720, 0, 0);
        check("R5 level 2 not delegated", pc_out, MTV);
        check("R8 mpie level 2", st_mpie, 0);
        check("R8 mpp level 2", st_mpp, 2);
    endtask

    task automatic t_trap_beats_ctx();
        do_reset();
        open_resv();
        @(negedge clk);
        trap_valid = 1; trap_cause = 32'd2; trap_epc = 32'h800;
        ctx_load = 1; ctx_priv = 2'd0; ctx_ie = 3'b111; resv_set = 1;
        @(negedge clk);
        trap_valid = 0; ctx_load = 0; resv_set = 0;
        check("R10 trap wins priv", priv_out, 3);
        check("R10 old priv stacked", st_mpp, 3);
        check("R10 ctx ie ignored", {st_uie, st_sie, st_mie}, 0);
        check("R10 resv_set ignored", resv_valid, 0);
        load_ctx(2'd1, 3'b011);
        check("R10 ctx load priv", priv_out, 1);
        check("R10 ctx load ie", {st_mie, st_sie, st_uie}, 3'b011);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_state();
        t_debug_entry_redirect();
        t_brk_disabled();
        t_super_exception();
        t_super_interrupt();
        t_irq_uses_ideleg();
        t_no_deleg_from_m();
        t_index_range();
        t_trap_beats_ctx();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule